// File: doc/BRIEF.md
# Translation Fault Status Capture

This block sits beside an address translation unit and keeps a record of the first translation fault it is told about. The translation logic reports a fault as a single-cycle pulse. The pulse comes with the stream identifier of the requester, a one-hot cause vector and the 64-bit address that failed. If no fault is recorded yet, the block stores these in a status word and a pair of address words. It then raises an interrupt. The record stays unchanged until software clears it.

Software reads the record through a simple 32-bit register port. It reads the status word, handles the fault, and then writes the same value back to the status offset. Status bits are write-one-to-clear, so the write-back empties the record. An optional per-cause mask register decides which recorded causes can drive the interrupt. Parameters select the field widths. A 4-bit stream field in bits 27:24 with a 12-bit cause field suits small units. An 8-bit stream field in bits 27:20 with a 15-bit cause field suits larger ones. In both layouts the stream field ends at bit 27.

Top module: `xlat_fault_latch`

## Requirements
- R1: After reset, the status word, both address words and `irq` read 0. The mask register reads all ones, one bit per cause bit (0xFFF in the default configuration).
- R2: While the valid flag (status bit 31) is set, a new fault pulse changes neither the status word nor the address words.
- R3: Status layout: bit 31 is the valid flag. The stream identifier is in bits 27:24. The cause vector, stored exactly as reported, is in bits 11:0. The cause encoding is one-hot: bit 0 means no table base, bit 1 means no middle-level entry, bit 2 means no leaf entry, bit 3 means write fault and bit 4 means read fault. All other status bits read 0.
- R4: A fault pulse that arrives with the record empty is captured at that clock edge. The register port can read the record on the next cycle. The address low word is at offset 0x50, the high word at 0x54, and the status word at 0x40.
- R5: A write to 0x40 clears each status bit whose write-data bit is 1. Writing back the value just read empties the record. Writing 0 changes nothing. Writing only some cause bits clears those bits and leaves the valid flag set.
- R6: The address words are read-only. They change only when a fault is captured, and writes to 0x50 or 0x54 are ignored.
- R7: `irq` is registered. It is 1 in the cycle after the record holds a set valid flag together with at least one cause bit whose mask bit is 0. Otherwise it is 0.
- R8: The mask register is at 0x44, with one bit per cause bit. A 1 suppresses that cause, and writing 0 enables every cause. A mask write takes effect on `irq` one cycle after the write.
- R9: If a fault pulse arrives in the same cycle as a write that clears the valid flag, the new fault is captured and not lost.
- R10: Read data is registered. It appears one cycle after `bus_rd`, unmapped offsets read 0, and `bus_rdata` is 0 in every cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_pulse | input | 1 | One-cycle fault report strobe |
| fault_sid | input | SID_W | Stream identifier of the faulting requester |
| fault_cause | input | CODE_W | One-hot cause vector |
| fault_addr | input | 64 | Faulting address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered fault interrupt |

## Verification
The hardest case to reach from the ports is a clearing write to the status offset and a new fault pulse landing on the same clock edge. A naive design would let the clear wipe out the fresh fault. The bench drives both strobes from the same falling edge and then reads back the second fault's stream, cause and address. It also holds a record while a second fault arrives. It applies a write that clears cause bits but leaves the valid flag set, so the interrupt drops while the record survives.

// File: rtl/xfl_pkg.sv
package xfl_pkg;
  localparam int XFL_VALID_BIT = 31;
  localparam int XFL_SID_END   = 28;   // stream field ends at bit 27
  localparam int XFL_OFF_STAT  = 'h40;
  localparam int XFL_OFF_MASK  = 'h44;
  localparam int XFL_OFF_ALO   = 'h50;
  localparam int XFL_OFF_AHI   = 'h54;
endpackage

// File: rtl/xfl_record.sv
module xfl_record #(
  parameter int SID_W  = 4,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulse,
  input  logic [SID_W-1:0]  sid,
  input  logic [CODE_W-1:0] cause,
  input  logic [63:0]       addr,
  input  logic              clr_en,
  input  logic [31:0]       clr_bits,
  output logic [31:0]       status_q,
  output logic [63:0]       addr_q
);
  import xfl_pkg::*;
  localparam int SID_LSB = XFL_SID_END - SID_W;

  logic [31:0] kept;
  logic [31:0] fresh;
  logic        take;

  always_comb begin
    kept  = clr_en ? (status_q & ~clr_bits) : status_q;
    take  = pulse && !kept[XFL_VALID_BIT];
    fresh = '0;
    fresh[XFL_VALID_BIT]        = 1'b1;
    fresh[SID_LSB +: SID_W]     = sid;
    fresh[CODE_W-1:0]           = cause;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      addr_q   <= '0;
    end else begin
      status_q <= take ? fresh : kept;
      if (take) addr_q <= addr;
    end
  end
endmodule

// File: rtl/xfl_mask_irq.sv
module xfl_mask_irq #(
  parameter int CODE_W   = 12,
  parameter bit HAS_MASK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_we,
  input  logic [CODE_W-1:0] mask_wdata,
  input  logic              rec_valid,
  input  logic [CODE_W-1:0] rec_code,
  output logic [CODE_W-1:0] mask_q,
  output logic              irq_q
);
  generate
    if (HAS_MASK) begin : g_mask
      always_ff @(posedge clk) begin
        if (rst)          mask_q <= '1;
        else if (mask_we) mask_q <= mask_wdata;
      end
    end else begin : g_nomask
      assign mask_q = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= rec_valid && |(rec_code & ~mask_q);
  end
endmodule

// File: rtl/xfl_readmux.sv
module xfl_readmux #(
  parameter int ADDR_W   = 8,
  parameter int CODE_W   = 12,
  parameter bit HAS_MASK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       status,
  input  logic [63:0]       fault_addr,
  input  logic [CODE_W-1:0] mask,
  output logic [31:0]       rdata_q
);
  import xfl_pkg::*;
  logic [31:0] sel;

  always_comb begin
    sel = '0;
    if (addr == ADDR_W'(XFL_OFF_STAT))                  sel = status;
    else if (addr == ADDR_W'(XFL_OFF_ALO))              sel = fault_addr[31:0];
    else if (addr == ADDR_W'(XFL_OFF_AHI))              sel = fault_addr[63:32];
    else if (HAS_MASK && addr == ADDR_W'(XFL_OFF_MASK)) sel = 32'(mask);
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= sel;
    else         rdata_q <= '0;
  end
endmodule

// File: rtl/xlat_fault_latch.sv
module xlat_fault_latch #(
  parameter int SID_W    = 4,
  parameter int CODE_W   = 12,
  parameter int ADDR_W   = 8,
  parameter bit HAS_MASK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault_pulse,
  input  logic [SID_W-1:0]  fault_sid,
  input  logic [CODE_W-1:0] fault_cause,
  input  logic [63:0]       fault_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  import xfl_pkg::*;

  logic [31:0]       rec_status;
  logic [63:0]       rec_addr;
  logic [CODE_W-1:0] mask_q;
  logic              stat_we;
  logic              mask_we;

  assign stat_we = bus_wr && (bus_addr == ADDR_W'(XFL_OFF_STAT));
  assign mask_we = bus_wr && (bus_addr == ADDR_W'(XFL_OFF_MASK));

  xfl_record #(.SID_W(SID_W), .CODE_W(CODE_W)) u_rec (
    .clk(clk), .rst(rst), .pulse(fault_pulse), .sid(fault_sid),
    .cause(fault_cause), .addr(fault_addr), .clr_en(stat_we),
    .clr_bits(bus_wdata), .status_q(rec_status), .addr_q(rec_addr)
  );

  xfl_mask_irq #(.CODE_W(CODE_W), .HAS_MASK(HAS_MASK)) u_irq (
    .clk(clk), .rst(rst), .mask_we(mask_we),
    .mask_wdata(bus_wdata[CODE_W-1:0]),
    .rec_valid(rec_status[XFL_VALID_BIT]),
    .rec_code(rec_status[CODE_W-1:0]),
    .mask_q(mask_q), .irq_q(irq)
  );

  xfl_readmux #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .HAS_MASK(HAS_MASK)) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr),
    .status(rec_status), .fault_addr(rec_addr), .mask(mask_q),
    .rdata_q(bus_rdata)
  );
endmodule

// File: rtl/xfl_checker.sv
module xfl_checker #(
  parameter int CODE_W = 12,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fault_pulse,
  input logic [63:0]       fault_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic [31:0]       rec_status,
  input logic [63:0]       rec_addr,
  input logic [CODE_W-1:0] mask_q
);
  logic stat_wr;
  assign stat_wr = bus_wr && (bus_addr == ADDR_W'('h40));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    rec_status[31] && !stat_wr |=> $stable(rec_status) && $stable(rec_addr));

  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    !rec_status[31] && fault_pulse |=> rec_status[31] && rec_addr == $past(fault_addr));

  a_r6_addr_only_on_fault: assert property (@(posedge clk) disable iff (rst)
    !fault_pulse |=> $stable(rec_addr));

  a_r7_no_record_no_irq: assert property (@(posedge clk) disable iff (rst)
    !rec_status[31] |=> !irq);

  a_r8_full_mask_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '1) |=> !irq);

  a_r9_clear_keeps_new: assert property (@(posedge clk) disable iff (rst)
    stat_wr && bus_wdata[31] && fault_pulse |=> rec_status[31] && rec_addr == $past(fault_addr));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == 32'd0);
endmodule

bind xlat_fault_latch xfl_checker #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .fault_pulse(fault_pulse), .fault_addr(fault_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq(irq), .rec_status(rec_status),
  .rec_addr(rec_addr), .mask_q(mask_q)
);

// File: tb/xlat_fault_latch_test.sv
module xlat_fault_latch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fault_pulse = 1'b0;
  logic [3:0]  fault_sid = '0;
  logic [11:0] fault_cause = '0;
  logic [63:0] fault_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xlat_fault_latch uut (
    .clk(clk), .rst(rst), .fault_pulse(fault_pulse), .fault_sid(fault_sid),
    .fault_cause(fault_cause), .fault_addr(fault_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic flt(input logic [3:0] s, input logic [11:0] c, input logic [63:0] a);
    @(negedge clk); fault_pulse = 1'b1; fault_sid = s; fault_cause = c; fault_addr = a;
    @(negedge clk); fault_pulse = 1'b0;
  endtask

  function automatic logic [31:0] stat_of(input logic [3:0] s, input logic [11:0] c);
    return 32'h8000_0000 | (32'(s) << 24) | 32'(c);
  endfunction

  function automatic logic [63:0] addr_of(input int s, input int c);
    return 64'h0123_4567_89AB_CDEF ^ (64'(s) * 64'h0001_0003_0007_000B) ^ (64'(c) << 40);
  endfunction

  initial begin
    logic [31:0] d;
    logic [31:0] st;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd('h40, d); chk("R1 status", 64'(d), 0);
    rd('h50, d); chk("R1 addr lo", 64'(d), 0);
    rd('h54, d); chk("R1 addr hi", 64'(d), 0);
    rd('h44, d); chk("R1 mask", 64'(d), 64'h0FFF);
    chk("R1 irq", 64'(irq), 0);

    // R8 masked at reset: record captured but no interrupt
    flt(4'h3, 12'h010, addr_of(3, 4));
    rd('h40, d); chk("R8 status under full mask", 64'(d), 64'(stat_of(4'h3, 12'h010)));
    chk("R8 irq suppressed", 64'(irq), 0);
    wr('h44, 32'h0);
    chk("R8 irq one cycle after unmask", 64'(irq), 0);
    rd('h44, d); chk("R8 mask cleared", 64'(d), 0);
    chk("R8 irq after unmask", 64'(irq), 1);
    wr('h40, d | stat_of(4'h3, 12'h010));
    rd('h40, d); chk("R5 cleared", 64'(d), 0);

    // Sweep every stream id and every cause bit
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 12; c++) begin
        flt(4'(s), 12'(1 << c), addr_of(s, c));
        chk("R7 irq latency", 64'(irq), 0);
        rd('h40, st); chk("R3 R4 status", 64'(st), 64'(stat_of(4'(s), 12'(1 << c))));
        chk("R7 irq raised", 64'(irq), 1);
        rd('h50, d); chk("R4 addr lo", 64'(d), 64'(addr_of(s, c) & 64'hFFFF_FFFF));
        rd('h54, d); chk("R4 addr hi", 64'(d), addr_of(s, c) >> 32);
        wr('h40, st);
        rd('h40, d); chk("R5 write-back clears", 64'(d), 0);
        chk("R7 irq dropped", 64'(irq), 0);
      end
    end

    // R2 hold first record; R6 address write ignored
    flt(4'h5, 12'h004, addr_of(5, 2));
    flt(4'hA, 12'h002, addr_of(10, 1));
    rd('h40, st); chk("R2 status held", 64'(st), 64'(stat_of(4'h5, 12'h004)));
    rd('h50, d); chk("R2 addr lo held", 64'(d), 64'(addr_of(5, 2) & 64'hFFFF_FFFF));
    wr('h50, 32'hDEAD_BEEF); wr('h54, 32'hCAFE_F00D);
    rd('h50, d); chk("R6 addr lo read-only", 64'(d), 64'(addr_of(5, 2) & 64'hFFFF_FFFF));
    rd('h54, d); chk("R6 addr hi read-only", 64'(d), addr_of(5, 2) >> 32);

    // R5 zero write no effect, partial clear keeps valid
    wr('h40, 32'h0);
    rd('h40, d); chk("R5 zero write", 64'(d), 64'(st));
    wr('h40, 32'h0000_0004);
    rd('h40, d); chk("R5 partial clear", 64'(d), 64'h8500_0000);
    chk("R7 no cause no irq", 64'(irq), 0);
    wr('h40, 32'h8500_0000);
    rd('h40, d); chk("R5 full clear", 64'(d), 0);

    // R9 clear and new fault in the same cycle
    flt(4'h1, 12'h008, addr_of(1, 3));
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 'h40; bus_wdata = stat_of(4'h1, 12'h008);
    fault_pulse = 1'b1; fault_sid = 4'hC; fault_cause = 12'h001; fault_addr = addr_of(12, 0);
    @(negedge clk);
    bus_wr = 1'b0; fault_pulse = 1'b0;
    rd('h40, st); chk("R9 new fault kept", 64'(st), 64'(stat_of(4'hC, 12'h001)));
    rd('h54, d); chk("R9 new addr kept", 64'(d), addr_of(12, 0) >> 32);
    wr('h40, st);

    // R8 per-cause mask
    wr('h44, 32'h0000_0008);
    flt(4'h2, 12'h008, addr_of(2, 3));
    rd('h40, st); chk("R8 masked cause irq", 64'(irq), 0);
    wr('h40, st);
    flt(4'h2, 12'h010, addr_of(2, 4));
    rd('h40, st); chk("R8 unmasked cause irq", 64'(irq), 1);
    wr('h40, st);

    // R10 unmapped read and idle data
    rd('h48, d); chk("R10 unmapped", 64'(d), 0);
    @(negedge clk); chk("R10 idle rdata", 64'(bus_rdata), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule